// File: doc/BRIEF.md
# Transfer Length Command Encoder

This block turns a byte count of up to 24 bits into the short series of 32-bit command entries that a serial flash controller's command queue expects. Each entry carries either an immediate count of at most 255 bytes or an exponent code meaning a power-of-two chunk of 256 bytes or more. A caller pulses start with the length, a command template and a receive-DMA flag. The block then streams entries out over a valid/ready handshake and pulses done after the last one has been accepted.

Counts above 255 are consumed one set bit at a time, lowest bit first, starting at bit 8. The scan moves up one bit index per clock. Once 255 or fewer bytes remain, a single immediate entry closes the series. In receive-DMA mode that last immediate count is padded up to a whole number of 4-byte words. The non-count fields of the template (direction, bus and chip selects, lane mode, data flag) pass through into every entry. Each entry has a byte count beside it, so a data stage can pace its FIFO.

Top module: `lnc_len_encoder`

## Requirements
- R1: After reset, and until a start is accepted, `ent_valid_o` and `done_o` are low.
- R2: While the remaining count is above 255, each entry has bit 9 set and holds in bits 7:0 the index of the lowest set bit of the remaining count at or above bit 8. That power of two is then taken off the remaining count.
- R3: When 1 to 255 bytes remain, one last entry is emitted. It has bit 9 clear and the remaining count in bits 7:0.
- R4: If exponent entries use up the whole count exactly, no immediate entry follows.
- R5: A start with length zero emits no entry, and `done_o` is high in the cycle right after the start is taken.
- R6: In receive-DMA mode the final immediate count is rounded up to a multiple of 4. Exponent entries are left unchanged.
- R7: In receive-DMA mode, a remainder of 253 to 255 rounds to 256. It is then emitted as an exponent entry with index 8 and a chunk length of 256.
- R8: Bits 31:10 and bit 8 of every entry equal the template captured at start.
- R9: While `ent_valid_o` is high and `ent_ready_i` is low, the entry and the chunk length hold steady and valid stays high.
- R10: `chunk_len_o` gives the bytes an entry stands for: 2 to the power of the index for an exponent entry, and the emitted count for an immediate entry.
- R11: `done_o` is a one-cycle pulse in the cycle after the last entry is accepted, and `ent_valid_o` is low during that pulse.
- R12: A start that arrives while a series is in progress is ignored.
- R13: With ready held high, each entry becomes valid at most 17 cycles after the start or the previous handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a series (taken only when idle) |
| len_i | input | 24 | Total byte count |
| tmpl_i | input | 32 | Command template; bits 9 and 7:0 are replaced |
| dma_rx_i | input | 1 | Pad the final immediate count to 4-byte words |
| ent_valid_o | output | 1 | Entry available |
| ent_ready_i | input | 1 | Consumer accepts entry |
| ent_o | output | 32 | Command entry |
| chunk_len_o | output | 24 | Bytes covered by the current entry |
| done_o | output | 1 | Series complete pulse |

## Verification
A corrupted remaining count or scan position shows up on the very next entry. The exponent index or the immediate count is wrong, so the total of the chunk lengths no longer matches the requested length. A bad remaining count can also cause a missing or extra final entry, which moves the done pulse from its expected cycle. A scan position that fails to advance or wraps stalls valid beyond the 17-cycle bound, or emits an index below 8. A stale captured template or mode flag corrupts the high entry bits or the word padding from the first entry of the next series.

// File: rtl/lnc_pkg.sv
package lnc_pkg;
  localparam int unsigned CMD_W    = 32;
  localparam int unsigned IMM_W    = 8;
  localparam int unsigned EXP_FLAG = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_EMIT
  } lnc_state_e;
endpackage

// File: rtl/lnc_bit_scan.sv
module lnc_bit_scan #(
  parameter int unsigned LEN_W = 24,
  parameter int unsigned START = 8,
  localparam int unsigned POS_W = $clog2(LEN_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [POS_W-1:0] pos_o,
  output logic             hit_o
);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   pos_q <= POS_W'(START);
    else if (load_i)                               pos_q <= POS_W'(START);
    else if (step_i && pos_q != POS_W'(LEN_W - 1)) pos_q <= pos_q + 1'b1;
  end

  assign pos_o = pos_q;
  assign hit_o = rem_i[pos_q];
endmodule

// File: rtl/lnc_entry_fmt.sv
module lnc_entry_fmt
  import lnc_pkg::*;
#(
  parameter int unsigned LEN_W = 24,
  parameter int unsigned ALIGN = 4,
  localparam int unsigned POS_W = $clog2(LEN_W),
  localparam int unsigned AL_W  = $clog2(ALIGN)
) (
  input  logic [CMD_W-1:0] tmpl_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             dma_i,
  output logic             small_o,
  output logic [CMD_W-1:0] ent_o,
  output logic [LEN_W-1:0] chunk_o,
  output logic             last_o
);
  localparam logic [CMD_W-1:0] CNT_MASK = CMD_W'((1 << IMM_W) - 1) | (CMD_W'(1) << EXP_FLAG);
  localparam logic [IMM_W:0]   AL_M1    = (IMM_W+1)'(ALIGN - 1);

  logic [CMD_W-1:0] base;
  logic [IMM_W:0]   imm;
  logic [IMM_W:0]   rnd;

  assign base    = tmpl_i & ~CNT_MASK;
  assign small_o = rem_i <= LEN_W'((1 << IMM_W) - 1);
  assign imm     = {1'b0, rem_i[IMM_W-1:0]};

  generate
    if (AL_W > 0) begin : g_round
      always_comb begin
        rnd = imm;
        if (dma_i && imm[AL_W-1:0] != '0) rnd = (imm + AL_M1) & ~AL_M1;
      end
    end else begin : g_noround
      assign rnd = imm;
    end
  endgenerate

  always_comb begin
    if (!small_o) begin
      ent_o   = base | (CMD_W'(1) << EXP_FLAG) | CMD_W'(pos_i);
      chunk_o = LEN_W'(1) << pos_i;
      last_o  = 1'b0;
    end else if (rnd[IMM_W]) begin
      // padded count overflowed the immediate field: one 2^IMM_W chunk
      ent_o   = base | (CMD_W'(1) << EXP_FLAG) | CMD_W'(IMM_W);
      chunk_o = LEN_W'(1) << IMM_W;
      last_o  = 1'b1;
    end else begin
      ent_o   = base | CMD_W'(rnd[IMM_W-1:0]);
      chunk_o = LEN_W'(rnd);
      last_o  = 1'b1;
    end
  end
endmodule

// File: rtl/lnc_len_encoder.sv
module lnc_len_encoder
  import lnc_pkg::*;
#(
  parameter int unsigned LEN_W = 24,
  parameter int unsigned ALIGN = 4,
  localparam int unsigned POS_W = $clog2(LEN_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CMD_W-1:0] tmpl_i,
  input  logic             dma_rx_i,
  output logic             ent_valid_o,
  input  logic             ent_ready_i,
  output logic [CMD_W-1:0] ent_o,
  output logic [LEN_W-1:0] chunk_len_o,
  output logic             done_o
);
  lnc_state_e       state_q;
  logic [LEN_W-1:0] rem_q, chunk_q, fmt_chunk;
  logic [CMD_W-1:0] tmpl_q, ent_q, fmt_ent;
  logic             dma_q, last_q, done_q;
  logic             fmt_small, fmt_last, hit, scan_load, scan_step, take;
  logic [POS_W-1:0] pos;

  assign take      = state_q == ST_IDLE && start_i;
  assign scan_load = take;
  assign scan_step = state_q == ST_SCAN && !fmt_small && !hit;

  lnc_bit_scan #(.LEN_W(LEN_W), .START(IMM_W)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (scan_load),
    .step_i (scan_step),
    .rem_i  (rem_q),
    .pos_o  (pos),
    .hit_o  (hit)
  );

  lnc_entry_fmt #(.LEN_W(LEN_W), .ALIGN(ALIGN)) u_fmt (
    .tmpl_i  (tmpl_q),
    .rem_i   (rem_q),
    .pos_i   (pos),
    .dma_i   (dma_q),
    .small_o (fmt_small),
    .ent_o   (fmt_ent),
    .chunk_o (fmt_chunk),
    .last_o  (fmt_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      tmpl_q  <= '0;
      dma_q   <= 1'b0;
      ent_q   <= '0;
      chunk_q <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rem_q  <= len_i;
          tmpl_q <= tmpl_i;
          dma_q  <= dma_rx_i;
          if (len_i == '0) done_q  <= 1'b1;
          else             state_q <= ST_SCAN;
        end
        ST_SCAN: if (fmt_small || hit) begin
          ent_q   <= fmt_ent;
          chunk_q <= fmt_chunk;
          last_q  <= fmt_last;
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (ent_ready_i) begin
          if (last_q || rem_q == chunk_q) begin
            rem_q   <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            rem_q   <= rem_q - chunk_q;
            state_q <= ST_SCAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ent_valid_o = state_q == ST_EMIT;
  assign ent_o       = ent_q;
  assign chunk_len_o = chunk_q;
  assign done_o      = done_q;
endmodule

// File: rtl/lnc_checker.sv
module lnc_checker #(
  parameter int unsigned LEN_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [31:0]      tmpl_i,
  input logic             dma_rx_i,
  input logic             ent_valid_o,
  input logic             ent_ready_i,
  input logic [31:0]      ent_o,
  input logic [LEN_W-1:0] chunk_len_o,
  input logic             done_o
);
  logic        busy_q, dma_q;
  logic [31:0] tmpl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dma_q  <= 1'b0;
      tmpl_q <= '0;
    end else if (!busy_q && start_i) begin
      busy_q <= 1'b1;
      dma_q  <= dma_rx_i;
      tmpl_q <= tmpl_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end

  a_r8_tmpl_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o |-> ent_o[31:10] == tmpl_q[31:10] && ent_o[8] == tmpl_q[8]);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && !ent_ready_i |=> ent_valid_o && $stable(ent_o) && $stable(chunk_len_o));

  a_r2_exp_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && ent_o[9] |-> ent_o[7:0] >= 8'd8 && ent_o[7:0] < 8'(LEN_W)
      && chunk_len_o == (LEN_W'(1) << ent_o[7:0]));

  a_r3_imm_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && !ent_o[9] |-> chunk_len_o == LEN_W'(ent_o[7:0]) && ent_o[7:0] != 8'd0);

  a_r6_dma_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && !ent_o[9] && dma_q |-> ent_o[1:0] == 2'b00);

  a_r11_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && ent_valid_o));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !start_i |=> !ent_valid_o);
endmodule

bind lnc_len_encoder lnc_checker #(.LEN_W(LEN_W)) u_lnc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .tmpl_i      (tmpl_i),
  .dma_rx_i    (dma_rx_i),
  .ent_valid_o (ent_valid_o),
  .ent_ready_i (ent_ready_i),
  .ent_o       (ent_o),
  .chunk_len_o (chunk_len_o),
  .done_o      (done_o)
);

// File: tb/tb_lnc_len_encoder.sv
module tb_lnc_len_encoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] len_i = '0;
  logic [31:0] tmpl_i = '0;
  logic        dma_rx_i = 1'b0;
  logic        ent_valid_o, ent_ready_i, done_o;
  logic [31:0] ent_o;
  logic [23:0] chunk_len_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] q_ent[$];
  logic [23:0] q_len[$];

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  lnc_len_encoder dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .tmpl_i(tmpl_i), .dma_rx_i(dma_rx_i), .ent_valid_o(ent_valid_o),
    .ent_ready_i(ent_ready_i), .ent_o(ent_o), .chunk_len_o(chunk_len_o),
    .done_o(done_o)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void build_exp(logic [23:0] len, logic [31:0] tmpl, bit dma);
    int rem = int'(len);
    logic [31:0] base = tmpl & ~32'h0000_02FF;
    q_ent.delete();
    q_len.delete();
    while (rem > 0) begin
      if (rem > 255) begin
        int b = 8;
        while (((rem >> b) & 1) == 0) b++;
        q_ent.push_back(base | 32'h200 | 32'(b));
        q_len.push_back(24'(1 << b));
        rem -= (1 << b);
      end else begin
        int n = rem;
        if (dma && (n % 4) != 0) n = (n + 3) & ~3;
        if (n == 256) q_ent.push_back(base | 32'h200 | 32'd8);
        else          q_ent.push_back(base | 32'(n));
        q_len.push_back(24'(n));
        rem = 0;
      end
    end
  endfunction

  task automatic run_case(string req, logic [23:0] len, logic [31:0] tmpl, bit dma,
                          bit stall, bit inject);
    int gap = 0, idx = 0;
    bit seen = 0, held = 0, got_done = 0;
    logic [31:0] held_ent;
    logic [23:0] held_len;
    build_exp(len, tmpl, dma);
    @(negedge clk_i);
    start_i = 1'b1; len_i = len; tmpl_i = tmpl; dma_rx_i = dma;
    for (int it = 0; it < 5000; it++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      gap++;
      if (inject && it == 3) begin
        start_i = 1'b1; len_i = 24'h000005; tmpl_i = ~tmpl; dma_rx_i = ~dma;
      end
      if (held) begin
        check(ent_valid_o == 1'b1, "R9", "valid dropped under stall", 64'(ent_valid_o), 64'd1);
        check(ent_o == held_ent && chunk_len_o == held_len, "R9", "entry moved under stall",
              64'(ent_o), 64'(held_ent));
        held = 0;
      end
      if (done_o) begin
        check(gap == 1, "R11", "done delay after last accept", 64'(gap), 64'd1);
        check(!ent_valid_o, "R11", "valid during done", 64'(ent_valid_o), 64'd0);
        got_done = 1;
        break;
      end
      ent_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (ent_valid_o && !seen) begin
        seen = 1;
        if (!stall) check(gap <= 17, "R13", "entry latency", 64'(gap), 64'd17);
      end
      if (ent_valid_o && ent_ready_i) begin
        if (idx < q_ent.size()) begin
          check(ent_o == q_ent[idx], req, $sformatf("entry %0d", idx), 64'(ent_o), 64'(q_ent[idx]));
          check(chunk_len_o == q_len[idx], "R10", $sformatf("chunk %0d", idx),
                64'(chunk_len_o), 64'(q_len[idx]));
        end else begin
          check(1'b0, req, "extra entry", 64'(ent_o), 64'd0);
        end
        idx++; gap = 0; seen = 0;
      end else if (ent_valid_o) begin
        held = 1; held_ent = ent_o; held_len = chunk_len_o;
      end
    end
    check(got_done, "R11", "done seen", 64'(got_done), 64'd1);
    check(idx == q_ent.size(), req, "entry count", 64'(idx), 64'(q_ent.size()));
    ent_ready_i = 1'b1;
    @(negedge clk_i);
    check(!done_o && !ent_valid_o, "R11", "quiet after done", 64'({done_o, ent_valid_o}), 64'd0);
  endtask

  task automatic test_reset();
    ent_ready_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(!ent_valid_o && !done_o, "R1", "outputs in reset", 64'({ent_valid_o, done_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(!ent_valid_o && !done_o, "R1", "outputs idle", 64'({ent_valid_o, done_o}), 64'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    run_case("R2", 24'h000123, 32'hA5C3_5100, 1'b0, 1'b0, 1'b0);
    run_case("R4", 24'h800000, 32'h0001_4100, 1'b0, 1'b0, 1'b0);
    run_case("R2", 24'hFFFFFF, 32'h0002_7D00, 1'b0, 1'b1, 1'b0);
    run_case("R5", 24'h000000, 32'h1234_5678, 1'b0, 1'b0, 1'b0);
    run_case("R6", 24'h00010A, 32'h0002_5100, 1'b1, 1'b0, 1'b0);
    run_case("R7", 24'h0002FD, 32'h0002_5100, 1'b1, 1'b1, 1'b0);
    run_case("R7", 24'h0000FF, 32'h0002_5100, 1'b1, 1'b0, 1'b0);
    run_case("R3", 24'h0000C8, 32'hFFFF_FCFF, 1'b0, 1'b0, 1'b0);
    run_case("R8", 24'h0007C5, 32'h5A5A_FEFF, 1'b0, 1'b1, 1'b0);
    run_case("R12", 24'h001234, 32'h0001_5100, 1'b0, 1'b0, 1'b1);
    run_case("R6", 24'h000401, 32'h0002_5100, 1'b1, 1'b0, 1'b0);
    finish_run();
  end
endmodule